// File: doc/BRIEF.md
# Timer Compare/Capture Channel

A 16-bit up-counting timer paired with one compare/capture register that runs in one of four modes. In the two compare modes the register sets the timer period: when the running count equals the register, the counter restarts from zero and an interrupt request is raised. This gives a period of the programmed value plus one. In the buffered compare variant, software writes land in a shadow buffer. The buffer is copied into the active register on a timer initialize, or on a selectable event (counter wrap or compare match), and every such copy also zeroes the counter.

In the two capture modes an external pin is synchronized, edge-detected and used to snapshot the running count into the same register, with an interrupt request. Either one chosen edge or both edges trigger the capture. A small register port writes the compare/capture register and the control word, and reads back the register, the control word and the live count.

Top module: `cc_timer`

## Requirements
- R1: After reset the register, control word and counter read 0, and `irq` and `ovf` are 0.
- R2: In mode 00 (plain compare), a write to address 0 updates the active register at once. While running, a count equal to the register produces `irq` high in the following cycle.
- R3: In compare modes 00 and 01, a match returns the counter to 0, so successive match requests are the register value plus one cycles apart.
- R4: When the running counter sits at 0xFFFF, it wraps to 0 and `ovf` pulses high in the next cycle.
- R5: In mode 01 (buffered compare), a write to address 0 goes only to the shadow buffer, and address 0 keeps reading the old active value until a load.
- R6: A control write with bit 5 (initialize) set zeroes the counter. In mode 01 it also copies the buffer into the active register.
- R7: In mode 01 with control bit 3 clear, the buffer loads on a counter wrap. With bit 3 set, it loads on a compare match. Each load zeroes the counter.
- R8: In mode 10 (single-edge capture), the edge chosen by control bit 2 (1 rising, 0 falling) stores the count into the register and raises `irq`. The other edge does nothing. Capture happens at the third rising clock edge after the pin changes, with the count of that cycle.
- R9: In mode 11 (dual-edge capture), rising and falling pin edges both capture and raise `irq`.
- R10: A capture takes precedence over a bus write to address 0 in the same cycle.
- R11: With control bit 4 (run) clear, the counter holds its value.
- R12: Control word layout: bits 1:0 mode, bit 2 edge select, bit 3 reload-on-match, bit 4 run, bit 5 initialize (a strobe that reads back as 0). Read address 0 returns the register, address 1 the control word, address 2 the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | Write address: 0 register, 1 control |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read address: 0 register, 1 control, 2 counter |
| rd_data | output | 16 | Read data (combinational) |
| cap_pin | input | 1 | Asynchronous capture input |
| irq | output | 1 | Interrupt request, one cycle per event |
| ovf | output | 1 | Counter wrap indication, one cycle per wrap |

## Verification
Two pairs of events can land on the same edge. A capture can meet a bus write to the register; the bench provokes this by timing the write strobe into the cycle the synchronized edge emerges, and requires the captured count, not the written word, to be read back. In buffered mode with the register at 0xFFFF, a compare match and a counter wrap fall together; the bench requires a single load, a zeroed counter and both `irq` and `ovf`, judged each cycle against a reference model.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int CW_DEF = 16;
    localparam int INIT_BIT = 5;

    typedef enum logic [1:0] {
        MD_CMP  = 2'b00,
        MD_DBUF = 2'b01,
        MD_CAP1 = 2'b10,
        MD_CAP2 = 2'b11
    } mode_e;

    typedef struct packed {
        logic  run;
        logic  reload_on_match;
        logic  edge_rise;
        mode_e mode;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    localparam logic [1:0] A_REG  = 2'd0;
    localparam logic [1:0] A_CTRL = 2'd1;
    localparam logic [1:0] A_CNT  = 2'd2;

    function automatic logic is_capture(mode_e m);
        return m[1];
    endfunction
endpackage

// File: rtl/cc_edge_det.sv
module cc_edge_det #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic rise,
    output logic fall
);
    logic [SYNC_STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[SYNC_STAGES-1:0], pin};
    end

    assign rise =  chain[SYNC_STAGES-1] & ~chain[SYNC_STAGES];
    assign fall = ~chain[SYNC_STAGES-1] &  chain[SYNC_STAGES];
endmodule

// File: rtl/cc_counter.sv
module cc_counter #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          clear,
    output logic [CW-1:0] cnt,
    output logic          wrap
);
    assign wrap = run && (cnt == '1);

    always_ff @(posedge clk) begin
        if (rst)        cnt <= '0;
        else if (clear) cnt <= '0;
        else if (run)   cnt <= cnt + 1'b1;
    end

    // R11
    hold_when_stopped_chk: assert property (@(posedge clk) disable iff (rst)
        (!run && !clear) |=> $stable(cnt));

    // R6
    clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
        clear |=> (cnt == '0));
endmodule

// File: rtl/cc_regs.sv
module cc_regs
    import tmr_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [1:0]    wr_addr,
    input  logic [CW-1:0] wr_data,
    input  logic          load,
    input  logic          cap_evt,
    input  logic [CW-1:0] cnt,
    output ctrl_t         ctrl,
    output logic [CW-1:0] active,
    output logic          init
);
    logic [CW-1:0] shadow;
    logic          wr_reg;
    logic          wr_ctl;

    assign wr_reg = wr_en && (wr_addr == A_REG);
    assign wr_ctl = wr_en && (wr_addr == A_CTRL);
    assign init   = wr_ctl && wr_data[INIT_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl   <= '0;
            shadow <= '0;
            active <= '0;
        end else begin
            if (wr_ctl)
                ctrl <= ctrl_t'(wr_data[CTRL_W-1:0]);
            if (wr_reg && ctrl.mode == MD_DBUF)
                shadow <= wr_data;
            if (load)
                active <= shadow;
            else if (cap_evt)
                active <= cnt;
            else if (wr_reg && ctrl.mode != MD_DBUF)
                active <= wr_data;
        end
    end

    // R5
    dbuf_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl.mode == MD_DBUF && !load) |=> $stable(active));

    // R10
    cap_wins_chk: assert property (@(posedge clk) disable iff (rst)
        cap_evt |=> (active == $past(cnt)));

    // R7
    reload_copy_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> (active == $past(shadow)));
endmodule

// File: rtl/cc_timer.sv
module cc_timer
    import tmr_pkg::*;
#(
    parameter int CW          = CW_DEF,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [1:0]    wr_addr,
    input  logic [CW-1:0] wr_data,
    input  logic [1:0]    rd_addr,
    output logic [CW-1:0] rd_data,
    input  logic          cap_pin,
    output logic          irq,
    output logic          ovf
);
    ctrl_t         ctrl;
    logic [CW-1:0] active;
    logic [CW-1:0] cnt;
    logic          init, wrap, match, load, clear, cap_evt, rise, fall;

    cc_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk(clk), .rst(rst), .pin(cap_pin), .rise(rise), .fall(fall)
    );

    cc_counter #(.CW(CW)) u_cnt (
        .clk(clk), .rst(rst), .run(ctrl.run), .clear(clear),
        .cnt(cnt), .wrap(wrap)
    );

    cc_regs #(.CW(CW)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .load(load), .cap_evt(cap_evt), .cnt(cnt),
        .ctrl(ctrl), .active(active), .init(init)
    );

    always_comb begin
        match   = !is_capture(ctrl.mode) && ctrl.run && (cnt == active);
        load    = (ctrl.mode == MD_DBUF) &&
                  (init || (ctrl.reload_on_match ? match : wrap));
        clear   = init || load || match;
        cap_evt = 1'b0;
        if (is_capture(ctrl.mode)) begin
            if (ctrl.mode == MD_CAP2) cap_evt = rise | fall;
            else                      cap_evt = ctrl.edge_rise ? rise : fall;
        end
    end

    always_comb begin
        case (rd_addr)
            A_REG:   rd_data = active;
            A_CTRL:  rd_data = CW'(ctrl);
            A_CNT:   rd_data = cnt;
            default: rd_data = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq <= 1'b0;
            ovf <= 1'b0;
        end else begin
            irq <= match | cap_evt;
            ovf <= wrap;
        end
    end

    // R2
    match_irq_chk: assert property (@(posedge clk) disable iff (rst)
        match |=> irq);

    // R3
    match_restart_chk: assert property (@(posedge clk) disable iff (rst)
        match |=> (cnt == '0));

    // R4
    ovf_source_chk: assert property (@(posedge clk) disable iff (rst)
        ovf |-> ($past(cnt) == '1));
endmodule

// File: tb/tb_cc_timer.sv
`timescale 1ns/1ps
module tb_cc_timer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic [1:0]  rd_addr = 2'd0;
    logic [15:0] rd_data;
    logic        cap_pin = 1'b0;
    logic        irq, ovf;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit live = 0;
    string ph = "R1";

    always #5 clk = ~clk;

    cc_timer dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .cap_pin(cap_pin), .irq(irq), .ovf(ovf)
    );

    // reference model, built from the requirements
    logic [15:0] m_cnt, m_act, m_buf;
    logic [1:0]  m_mode;
    logic        m_edge, m_rel, m_run, m_irq, m_ovf;
    logic [2:0]  m_s;
    logic        t_mt, t_wp, t_ld, t_ini, t_ce, t_rs, t_fl;

    always @(posedge clk) begin
        if (rst) begin
            m_cnt <= 0; m_act <= 0; m_buf <= 0; m_mode <= 0;
            m_edge <= 0; m_rel <= 0; m_run <= 0; m_irq <= 0; m_ovf <= 0;
            m_s <= 0;
        end else begin
            t_ini = wr_en && wr_addr == 2'd1 && wr_data[5];
            t_mt  = (m_mode < 2) && m_run && (m_cnt == m_act);
            t_wp  = m_run && (m_cnt == 16'hFFFF);
            t_ld  = (m_mode == 1) && (t_ini || (m_rel ? t_mt : t_wp));
            t_rs  = m_s[1] & ~m_s[2];
            t_fl  = ~m_s[1] & m_s[2];
            t_ce  = (m_mode >= 2) && ((m_mode == 3) ? (t_rs | t_fl) : (m_edge ? t_rs : t_fl));
            m_s   <= {m_s[1:0], cap_pin};
            m_irq <= t_mt | t_ce;
            m_ovf <= t_wp;
            if (t_ini || t_ld || t_mt) m_cnt <= 0;
            else if (m_run)            m_cnt <= m_cnt + 1;
            if (wr_en && wr_addr == 2'd0 && m_mode == 1) m_buf <= wr_data;
            if (t_ld)       m_act <= m_buf;
            else if (t_ce)  m_act <= m_cnt;
            else if (wr_en && wr_addr == 2'd0 && m_mode != 1) m_act <= wr_data;
            if (wr_en && wr_addr == 2'd1) begin
                m_mode <= wr_data[1:0]; m_edge <= wr_data[2];
                m_rel  <= wr_data[3];   m_run  <= wr_data[4];
            end
        end
    end

    function automatic logic [15:0] m_rd(logic [1:0] a);
        case (a)
            2'd0:    return m_act;
            2'd1:    return {11'd0, m_run, m_rel, m_edge, m_mode};
            2'd2:    return m_cnt;
            default: return 16'd0;
        endcase
    endfunction

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        #3;
        if (live && !rst && !done) begin
            chk({ph, " rd_data"}, rd_data, m_rd(rd_addr));
            chk({ph, " irq"}, {15'd0, irq}, {15'd0, m_irq});
            chk({ph, " ovf"}, {15'd0, ovf}, {15'd0, m_ovf});
        end
    end

    task automatic wr(logic [1:0] a, logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_now(logic [1:0] a, output logic [15:0] v);
        rd_addr = a; #1; v = rd_data;
    endtask

    task automatic finish_run();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #1_500_000;
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [15:0] v, c0;
        int n1, n2, cyc, seed;
        bit seen;
        seed = $urandom(1234);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        rd_now(2'd0, v); chk("R1 reg", v, 16'd0);
        rd_now(2'd1, v); chk("R1 ctrl", v, 16'd0);
        rd_now(2'd2, v); chk("R1 cnt", v, 16'd0);
        chk("R1 irq/ovf", {14'd0, irq, ovf}, 16'd0);
        live = 1;

        // R2 / R3 plain compare, period value+1
        ph = "R2";
        wr(2'd0, 16'd5);
        rd_now(2'd0, v); chk("R2 reg write", v, 16'd5);
        wr(2'd1, 16'h0030);
        rd_now(2'd1, v); chk("R12 ctrl readback", v, 16'h0010);
        ph = "R3";
        n1 = 0; n2 = 0; cyc = 0;
        while (n2 == 0 && cyc < 50) begin
            @(negedge clk); #1; cyc++;
            if (irq) begin if (n1 == 0) n1 = cyc; else n2 = cyc; end
        end
        chk("R3 period", 16'(n2 - n1), 16'd6);

        // R11 stop holds counter
        ph = "R11";
        wr(2'd1, 16'h0000);
        rd_now(2'd2, c0);
        repeat (5) @(negedge clk);
        rd_now(2'd2, v); chk("R11 hold", v, c0);

        // R5 buffered write is not visible yet
        ph = "R5";
        wr(2'd1, 16'h0001);
        wr(2'd0, 16'hFFFF);
        rd_now(2'd0, v); chk("R5 old value", v, 16'd5);

        // R6 initialize loads buffer, zeroes counter
        ph = "R6";
        wr(2'd1, 16'h0031);
        rd_now(2'd2, v); chk("R6 cnt zero", v, 16'd0);
        rd_now(2'd0, v); chk("R6 loaded", v, 16'hFFFF);

        // R4 + R7: match and wrap coincide at 0xFFFF, wrap-driven reload
        ph = "R4";
        wr(2'd0, 16'h0010);
        seen = 0; cyc = 0;
        while (!seen && cyc < 70000) begin
            @(negedge clk); #1; cyc++;
            if (ovf) seen = 1;
        end
        chk("R4 ovf seen", {15'd0, seen}, 16'd1);
        rd_now(2'd0, v); chk("R7 wrap reload", v, 16'h0010);
        rd_now(2'd2, v); chk("R7 cnt after load", v, 16'd0);

        // R7 match-driven reload
        ph = "R7";
        wr(2'd1, 16'h0019);
        wr(2'd0, 16'h0020);
        seen = 0; cyc = 0;
        while (!seen && cyc < 100) begin
            @(negedge clk); #1; cyc++;
            if (irq) seen = 1;
        end
        rd_now(2'd0, v); chk("R7 match reload", v, 16'h0020);

        // R8 rising-edge capture, falling ignored
        ph = "R8";
        wr(2'd1, 16'h0016);
        repeat (4) @(negedge clk);
        cap_pin = 1'b1;
        rd_now(2'd2, c0);
        repeat (3) @(negedge clk);
        #1;
        chk("R8 irq", {15'd0, irq}, 16'd1);
        rd_now(2'd0, v); chk("R8 captured", v, c0 + 16'd2);
        c0 = v;
        @(negedge clk);
        cap_pin = 1'b0;
        repeat (5) @(negedge clk);
        rd_now(2'd0, v); chk("R8 falling ignored", v, c0);

        // R9 dual edges
        ph = "R9";
        wr(2'd1, 16'h0013);
        repeat (2) @(negedge clk);
        for (int k = 0; k < 2; k++) begin
            cap_pin = ~cap_pin;
            rd_now(2'd2, c0);
            repeat (3) @(negedge clk);
            rd_now(2'd0, v); chk("R9 capture", v, c0 + 16'd2);
            repeat (2) @(negedge clk);
        end

        // R10 capture beats same-cycle write
        ph = "R10";
        cap_pin = ~cap_pin;
        rd_now(2'd2, c0);
        @(negedge clk);
        @(negedge clk);
        wr(2'd0, 16'hBEEF);
        rd_now(2'd0, v); chk("R10 capture wins", v, c0 + 16'd2);

        // random phase
        for (int i = 0; i < 3000; i++) begin
            case (m_mode)
                2'd0: ph = "R2";
                2'd1: ph = "R5";
                2'd2: ph = "R8";
                default: ph = "R9";
            endcase
            rd_addr = 2'($urandom_range(0, 2));
            if ($urandom_range(0, 7) == 0) cap_pin = ~cap_pin;
            if ($urandom_range(0, 15) == 0) begin
                wr_en = 1'b1;
                wr_addr = 2'($urandom_range(0, 1));
                if (wr_addr == 2'd0) wr_data = 16'($urandom_range(0, 255));
                else begin
                    wr_data = 16'($urandom_range(0, 31)) | 16'h0010;
                    if ($urandom_range(0, 3) == 0) wr_data[5] = 1'b1;
                end
            end else wr_en = 1'b0;
            @(negedge clk);
        end
        wr_en = 1'b0;
        @(negedge clk);
        finish_run();
    end
endmodule